// File: doc/BRIEF.md
# Leaky-Bucket Signal Unit Error Monitor

This block keeps a running figure of merit for the quality of one receive signalling channel. A 6-bit merit counter goes up when frames arrive damaged and comes down slowly while clean traffic flows. An upstream HDLC-style receiver supplies one status strobe per frame end: clean message, short frame, long frame, octet alignment error and CRC mismatch. It also supplies an abort strobe for seven ones in a row and a strobe for each received octet. A host, or a link-state machine, reads the merit value and reacts to the one-cycle step pulses.

The merit counter can be raised in two ways. The first is a frame error: a short frame, an alignment error or a CRC mismatch. The second is a bad-octet mode, which starts on an abort or an over-length frame. In that mode every sixteen received octets add one count. A 256-count integrator of clean messages lowers the merit counter by one each time it rolls over. The integrator does not move while bad-octet mode is active, because only a clean message can end the mode.

There is no data stream at this block's edge, so there is no valid/ready pair and no back-pressure. Every input is a plain strobe that is sampled on each rising clock edge. The block never stalls, and a strobe is never held back for a later cycle. All outputs are registered.

Top module: `su_err_monitor`

## Requirements
- R1: A synchronous active-low reset clears the merit counter, the bad-octet counter, the clean-message integrator and the mode flag. While reset is low, and in the first cycle after it is released, every output reads zero.
- R2: A frame-end cycle with any of `frm_short_i`, `frm_align_i` or `frm_crc_i` high counts as exactly one error, even when several of these flags are high together. In the following cycle, each flag that was high drives its own interrupt output high for exactly one cycle.
- R3: The merit counter updates on the clock edge that samples the strobes. For the cycle after that edge, `merit_inc_o` is high exactly when the increments applied that cycle raised the merit counter, and `merit_dec_o` is high exactly when the decrement applied that cycle lowered it. When neither pulse is high, the merit counter holds its value.
- R4: The merit counter saturates at 63 on increment and at 0 on decrement. It never wraps, and a step that saturation blocks produces no pulse.
- R5: Bad-octet mode is entered when `abort_i` or `frm_long_i` is high. Entry from the idle state clears the 4-bit bad-octet counter. An abort or long frame that arrives while the mode is already active leaves that counter untouched.
- R6: While the mode is active, each `octet_i` strobe advances the bad-octet counter. When the counter wraps from 15 to 0 on the 16th octet, the merit counter rises by one. Octet strobes that arrive outside the mode have no effect.
- R7: Only a clean message ends bad-octet mode. A clean message is `msg_good_i` high with `frm_short_i`, `frm_long_i`, `frm_align_i` and `frm_crc_i` all low. A `msg_good_i` strobe with any of those flags high is not clean.
- R8: Each clean message advances the 8-bit integrator, including the clean message that ends bad-octet mode. The integrator ignores errored frames and octets, so it holds its value through the mode. When it wraps from 255 to 0 on the 256th clean message, the merit counter falls by one.
- R9: A frame-error increment and an octet wrap in the same cycle raise the merit counter by two. When a decrement coincides with increments, the increments are applied first, with saturation, and the decrement is applied after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_good_i | input | 1 | Frame ended with a good check |
| frm_short_i | input | 1 | Frame ended too short |
| frm_long_i | input | 1 | Frame exceeded the maximum length |
| frm_align_i | input | 1 | Frame ended off an octet boundary |
| frm_crc_i | input | 1 | Frame check sequence mismatch |
| abort_i | input | 1 | Seven consecutive ones seen |
| octet_i | input | 1 | One octet received |
| merit_o | output | MERIT_W (6) | Current merit counter value |
| merit_inc_o | output | 1 | Merit counter rose this cycle |
| merit_dec_o | output | 1 | Merit counter fell this cycle |
| short_irq_o | output | 1 | Short-frame interrupt pulse |
| align_irq_o | output | 1 | Alignment-error interrupt pulse |
| crc_irq_o | output | 1 | CRC-mismatch interrupt pulse |

## Verification
The assertions assume two things about the environment: reset is held low from the first clock edge, and each status strobe lasts one cycle per event. Under those assumptions, the interrupt and step-pulse properties depend only on registered state. The stimulus drives every strobe for a single cycle and keeps the inputs at zero during reset. It combines events in one cycle only on purpose, for example an octet wrap together with a frame error or with a clean message, to reach the ordering cases of R9.

// File: rtl/su_mon_pkg.sv
package su_mon_pkg;

  typedef struct packed {
    logic good;
    logic short_f;
    logic long_f;
    logic align_f;
    logic crc_f;
  } frame_flags_t;

  localparam int unsigned IRQ_N = 3;

  function automatic logic frame_error(frame_flags_t f);
    return f.short_f | f.align_f | f.crc_f;
  endfunction

  function automatic logic clean_msg(frame_flags_t f);
    return f.good & ~(f.short_f | f.long_f | f.align_f | f.crc_f);
  endfunction

endpackage

// File: rtl/sumon_octet_run.sv
module sumon_octet_run #(
  parameter int unsigned OCT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic exit_i,
  input  logic octet_i,
  output logic mode_o,
  output logic wrap_o
);

  logic [OCT_W-1:0] cnt_q;
  logic             mode_q;

  assign wrap_o = mode_q & octet_i & (cnt_q == {OCT_W{1'b1}});
  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      if (enter_i && !mode_q)
        cnt_q <= '0;
      else if (mode_q && octet_i)
        cnt_q <= cnt_q + 1'b1;
      if (enter_i)
        mode_q <= 1'b1;
      else if (exit_i)
        mode_q <= 1'b0;
    end
  end

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> cnt_q == '0); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !$past(mode_q)) |-> cnt_q == $past(cnt_q)); // R6

endmodule

// File: rtl/sumon_good_integ.sv
module sumon_good_integ #(
  parameter int unsigned GOOD_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clean_i,
  output logic wrap_o
);

  logic [GOOD_W-1:0] cnt_q;

  assign wrap_o = clean_i & (cnt_q == {GOOD_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clean_i)
      cnt_q <= cnt_q + 1'b1;
  end

  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrap_o) |-> cnt_q == '0); // R8

endmodule

// File: rtl/sumon_merit.sv
module sumon_merit #(
  parameter int unsigned MERIT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_a_i,
  input  logic               inc_b_i,
  input  logic               dec_i,
  output logic [MERIT_W-1:0] merit_o,
  output logic               inc_o,
  output logic               dec_o
);

  localparam int unsigned SUM_W = MERIT_W + 2;
  localparam logic [MERIT_W-1:0] TOP = {MERIT_W{1'b1}};

  logic [MERIT_W-1:0] merit_q, after_inc, nxt;
  logic [SUM_W-1:0]   sum;
  logic               inc_q, dec_q, inc_ev, dec_ev;

  always_comb begin
    sum = {2'b00, merit_q} + {{(SUM_W-1){1'b0}}, inc_a_i}
                           + {{(SUM_W-1){1'b0}}, inc_b_i};
    after_inc = (sum > {2'b00, TOP}) ? TOP : sum[MERIT_W-1:0];
    inc_ev    = (after_inc != merit_q);
    dec_ev    = dec_i && (after_inc != '0);
    nxt       = dec_ev ? after_inc - 1'b1 : after_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      merit_q <= '0;
      inc_q   <= 1'b0;
      dec_q   <= 1'b0;
    end else begin
      merit_q <= nxt;
      inc_q   <= inc_ev;
      dec_q   <= dec_ev;
    end
  end

  assign merit_o = merit_q;
  assign inc_o   = inc_q;
  assign dec_o   = dec_q;

  AST_INC_GOES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q && !dec_q) |-> merit_q > $past(merit_q)); // R3
  AST_DEC_GOES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q && !inc_q) |-> merit_q < $past(merit_q)); // R3
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_q && !dec_q) |-> merit_q == $past(merit_q)); // R3
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(merit_q) == TOP) |-> merit_q >= TOP - 1'b1); // R4
  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(merit_q) == '0) |-> merit_q <= 2); // R4
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(merit_q) <= 32'($past(merit_q)) + 2); // R9

endmodule

// File: rtl/su_err_monitor.sv
module su_err_monitor
  import su_mon_pkg::*;
#(
  parameter int unsigned MERIT_W = 6,
  parameter int unsigned OCT_W   = 4,
  parameter int unsigned GOOD_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_good_i,
  input  logic               frm_short_i,
  input  logic               frm_long_i,
  input  logic               frm_align_i,
  input  logic               frm_crc_i,
  input  logic               abort_i,
  input  logic               octet_i,
  output logic [MERIT_W-1:0] merit_o,
  output logic               merit_inc_o,
  output logic               merit_dec_o,
  output logic               short_irq_o,
  output logic               align_irq_o,
  output logic               crc_irq_o
);

  localparam logic [MERIT_W-1:0] TOP = {MERIT_W{1'b1}};

  frame_flags_t     flags;
  logic             err_ev, clean_ev, enter_ev;
  logic             oct_wrap, good_wrap, mode;
  logic [IRQ_N-1:0] err_vec, irq_q;

  assign flags = '{good: msg_good_i, short_f: frm_short_i, long_f: frm_long_i,
                   align_f: frm_align_i, crc_f: frm_crc_i};

  assign err_ev   = frame_error(flags);
  assign clean_ev = clean_msg(flags);
  assign enter_ev = abort_i | frm_long_i;

  sumon_octet_run #(.OCT_W(OCT_W)) u_oct (
    .clk(clk), .rst_n(rst_n), .enter_i(enter_ev), .exit_i(clean_ev),
    .octet_i(octet_i), .mode_o(mode), .wrap_o(oct_wrap)
  );

  sumon_good_integ #(.GOOD_W(GOOD_W)) u_good (
    .clk(clk), .rst_n(rst_n), .clean_i(clean_ev), .wrap_o(good_wrap)
  );

  sumon_merit #(.MERIT_W(MERIT_W)) u_merit (
    .clk(clk), .rst_n(rst_n), .inc_a_i(err_ev), .inc_b_i(oct_wrap),
    .dec_i(good_wrap), .merit_o(merit_o), .inc_o(merit_inc_o),
    .dec_o(merit_dec_o)
  );

  assign err_vec = {frm_crc_i, frm_align_i, frm_short_i};

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= err_vec[i];
    end
  end

  assign short_irq_o = irq_q[0];
  assign align_irq_o = irq_q[1];
  assign crc_irq_o   = irq_q[2];

  AST_IRQ_RAISES_MERIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> (merit_inc_o || merit_o == TOP)); // R2
  AST_CLEAN_LEAVES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clean_ev) && !$past(enter_ev)) |-> !mode); // R7

endmodule

// File: tb/sim_su_err_monitor.sv
`timescale 1ns/1ps
module sim_su_err_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic g_i = 0, sh_i = 0, lg_i = 0, al_i = 0, cr_i = 0, ab_i = 0, oc_i = 0;
  logic [5:0] merit;
  logic inc_p, dec_p, sh_irq, al_irq, cr_irq;

  always #2 clk = ~clk;

  su_err_monitor u0 (
    .clk(clk), .rst_n(rst_n), .msg_good_i(g_i), .frm_short_i(sh_i),
    .frm_long_i(lg_i), .frm_align_i(al_i), .frm_crc_i(cr_i),
    .abort_i(ab_i), .octet_i(oc_i), .merit_o(merit), .merit_inc_o(inc_p),
    .merit_dec_o(dec_p), .short_irq_o(sh_irq), .align_irq_o(al_irq),
    .crc_irq_o(cr_irq)
  );

  typedef struct {
    int    stamp;
    int    merit;
    bit    inc, dec, sh, al, cr;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  int rm_merit = 0, rm_oct = 0, rm_good = 0;
  bit rm_mode = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item whose consuming edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (merit !== 6'(e.merit) || inc_p !== e.inc || dec_p !== e.dec ||
          sh_irq !== e.sh || al_irq !== e.al || cr_irq !== e.cr) begin
        errors++;
        $display("FAIL %s: got merit=%0d inc=%0b dec=%0b irq=%0b%0b%0b exp merit=%0d inc=%0b dec=%0b irq=%0b%0b%0b",
                 e.tag, merit, inc_p, dec_p, sh_irq, al_irq, cr_irq,
                 e.merit, e.inc, e.dec, e.sh, e.al, e.cr);
      end
    end
  end

  // driver with requirement-level reference model
  task automatic drive(input bit g, sh, lg, al, cr, ab, oc, input string tag);
    exp_t e;
    bit err, clean, enter, owrap, gwrap;
    int a;
    @(posedge clk);
    #1;
    g_i = g; sh_i = sh; lg_i = lg; al_i = al; cr_i = cr; ab_i = ab; oc_i = oc;
    err   = sh | al | cr;
    clean = g & !(sh | lg | al | cr);
    enter = ab | lg;
    owrap = 0;
    if (rm_mode && oc) begin
      if (rm_oct == 15) begin owrap = 1; rm_oct = 0; end
      else rm_oct++;
    end
    if (enter && !rm_mode) rm_oct = 0;
    gwrap = clean && (rm_good == 255);
    if (clean) rm_good = (rm_good + 1) % 256;
    if (enter) rm_mode = 1;
    else if (clean) rm_mode = 0;
    a = rm_merit + int'(err) + int'(owrap);
    if (a > 63) a = 63;
    e.inc = (a != rm_merit);
    e.dec = gwrap && (a != 0);
    rm_merit = e.dec ? a - 1 : a;
    e.merit = rm_merit;
    e.sh = sh; e.al = al; e.cr = cr;
    e.stamp = cyc;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic octets(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic cleans(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset;
    idle(1, "R1 settle");
    while (q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
    rst_n = 0;
    g_i = 0; sh_i = 0; lg_i = 0; al_i = 0; cr_i = 0; ab_i = 0; oc_i = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++;
    if (merit !== 0 || inc_p || dec_p || sh_irq || al_irq || cr_irq) begin
      errors++;
      $display("FAIL R1: in reset merit=%0d pulses=%0b%0b exp 0", merit, inc_p, dec_p);
    end
    rst_n = 1;
    rm_merit = 0; rm_oct = 0; rm_good = 0; rm_mode = 0;
    @(negedge clk);
    checks++;
    if (merit !== 0 || inc_p || dec_p) begin
      errors++;
      $display("FAIL R1: after reset merit=%0d exp 0", merit);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got no end exp end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: single and combined frame errors
    drive(0, 0, 0, 0, 1, 0, 0, "R2 crc");
    drive(0, 0, 0, 0, 1, 0, 0, "R2 crc");
    drive(0, 1, 0, 0, 0, 0, 0, "R2 short");
    drive(0, 0, 0, 1, 0, 0, 0, "R2 align");
    drive(0, 1, 0, 1, 1, 0, 0, "R2 combined one count");
    idle(2, "R3 quiet");
    // R6: octets outside the mode are ignored
    octets(20, "R6 idle octets");
    // R5/R6: abort enters, every 16 octets add one
    drive(0, 0, 0, 0, 0, 1, 0, "R5 abort entry");
    octets(40, "R6 octet wraps");
    // R7: good with an error flag is not clean, mode continues
    drive(1, 0, 0, 0, 1, 0, 0, "R7 errored good");
    octets(8, "R7 still counting");
    cleans(1, "R7 clean exit");
    octets(20, "R7 octets after exit");
    // R5: entry from idle clears, re-entry while active does not
    drive(0, 0, 1, 0, 0, 0, 0, "R5 long entry");
    octets(10, "R5 partial");
    cleans(1, "R5 exit");
    drive(0, 0, 0, 0, 0, 1, 0, "R5 re-entry clears");
    octets(10, "R5 after clear");
    octets(6, "R5 wrap after clear");
    drive(0, 0, 0, 0, 0, 1, 0, "R5 abort while active");
    octets(8, "R5 active half");
    drive(0, 0, 0, 0, 0, 1, 0, "R5 abort while active");
    octets(8, "R5 no clear when active");
    cleans(1, "R7 exit");
    // R8: integrator holds through mode, exit message counts
    do_reset();
    cleans(100, "R8 clean run");
    drive(0, 0, 0, 0, 0, 1, 0, "R8 enter");
    octets(30, "R8 mode octets");
    drive(0, 0, 0, 0, 1, 0, 0, "R8 crc in mode");
    drive(0, 1, 0, 0, 0, 0, 0, "R8 short in mode");
    cleans(1, "R8 exit counted");
    cleans(155, "R8 to 256th");
    idle(2, "R8 after dec");
    // R4: saturation at both ends
    do_reset();
    cleans(256, "R4 dec blocked at 0");
    for (int i = 0; i < 70; i++) drive(0, 0, 0, 0, 1, 0, 0, "R4 saturate at 63");
    // R9: two counts in one cycle
    do_reset();
    drive(0, 0, 0, 0, 0, 1, 0, "R9 enter");
    octets(15, "R9 fill");
    drive(0, 0, 0, 0, 1, 0, 1, "R9 double increment");
    // R9: increments first, then decrement, at the top
    do_reset();
    cleans(255, "R9 integrator to 255");
    for (int i = 0; i < 63; i++) drive(0, 0, 0, 0, 1, 0, 0, "R9 fill merit");
    drive(0, 0, 0, 0, 0, 1, 0, "R9 enter");
    octets(15, "R9 octet fill");
    drive(1, 0, 0, 0, 0, 0, 1, "R9 inc then dec");
    idle(3, "R9 tail");
    while (q.size() != 0) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule